// File: doc/BRIEF.md
# Serial Transmit Path with Selectable Holding Buffer

This block is the sending half of an asynchronous serial port. A host pushes bytes into a holding stage. The stage is either a single byte register or, when buffered mode is selected, a 16-entry first-in first-out buffer. Whenever the shift register is free and the stage holds data, the oldest byte moves into the shift register. It then goes out on the line as one frame: a low start bit, the data bits least significant first, an optional parity bit, and one high stop bit.

All bit timing comes from an oversampling enable pulse that runs at sixteen times the baud rate. The block does not generate that pulse. Two status outputs tell the host how far transmission has progressed. One shows that the holding stage is empty. The other shows that the whole path, shifter included, has gone quiet. An interrupt marks the moment the holding stage drains, so the host can refill it. This interrupt is an edge event that stays latched until the host services it, and it is not a level copy of the empty flag.

Top module: `serial_tx_path`

## Requirements
- R1: The line idles high. Each frame is a start bit (0), then wordLen+5 data bits least significant first (wordLen 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8), then the optional parity bit, then one stop bit (1).
- R2: Every serial bit lasts exactly 16 cycles on which tick16 is high. Cycles without tick16 never change the line while a frame is in progress.
- R3: With parityEn=1, a parity bit follows the data. With parityOdd=0 the count of ones in data plus parity is even. With parityOdd=1 that count is odd.
- R4: With fifoMode=0 the holding stage keeps one byte. A write is taken if the stage is empty, or if its byte moves to the shifter in the same cycle. Any other write is dropped and never sent.
- R5: With fifoMode=1 the stage keeps up to 16 bytes and sends them in write order. A write that finds 16 bytes stored, with no transfer to the shifter in that cycle, is dropped.
- R6: holdEmpty is high exactly when the holding stage stores no byte. It goes low in the cycle after an accepted write and high again after the last stored byte moves to the shifter.
- R7: txEmpty is high only when both the holding stage and the shift register are empty. It stays low while the final frame is still on the line.
- R8: When a byte is waiting at the end of a stop bit, the next start bit begins right away, with no idle time between frames.
- R9: An interrupt becomes pending when the holding stage changes from holding data to empty. Reset alone never makes one pending. txIrq is the pending flag masked by irqEnable, and a pending event survives while it is masked.
- R10: Any host write clears the pending interrupt, and so does a pulse on irqAck. A write takes priority over a new empty event in the same cycle.
- R11: After reset, txd=1, holdEmpty=1, txEmpty=1 and txIrq=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at sixteen times the baud rate |
| fifoMode | input | 1 | 1 selects the 16-entry buffer, 0 the single holding register |
| wordLen | input | 2 | Data bits per frame minus five |
| parityEn | input | 1 | Adds a parity bit after the data |
| parityOdd | input | 1 | 1 selects odd parity, 0 even |
| wrValid | input | 1 | Host write strobe into the holding stage |
| wrData | input | 8 | Byte being written |
| irqEnable | input | 1 | Mask for the empty interrupt |
| irqAck | input | 1 | Pulse that clears a pending interrupt, as when the host reads interrupt status |
| txd | output | 1 | Serial line output |
| holdEmpty | output | 1 | Holding stage empty |
| txEmpty | output | 1 | Holding stage and shift register both empty |
| txIrq | output | 1 | Masked empty interrupt |

## Verification
The bench sweeps all 16 combinations of word length and parity setting and decodes each frame at mid-bit from the tick count. A wrong bit period shows up as sliding samples, a reversed bit order as a mirrored byte, and an inverted parity sense as a parity mismatch. Two overflow cases are covered. In the single-register case, a write that lands in the same cycle as the transfer to the shifter must be kept and the next one dropped. In the buffered case, the seventeenth stored byte must be dropped. A design that gets either wrong sends an extra frame, loses a byte or reorders the bytes. The bench also holds the tick low in mid-frame to catch a shifter that runs off the clock rather than the enable. It checks that back-to-back frames leave no idle gap. Finally, it shows that a masked interrupt stays latched, and that a write clears it where a level-driven design would keep asserting.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  // Widest character the shifter carries; word length spans 5 to this.
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned MIN_CHAR = 5;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PARITY,
    TX_STOP
  } txState_t;

  // Strobes the controller issues to the datapath each cycle.
  typedef struct packed {
    logic push;   // store wrData into the holding stage
    logic load;   // move the oldest byte into the shift register
    logic shift;  // advance the shift register by one data bit
  } txStrobe_t;

endpackage

// File: rtl/serial_tx_data.sv
module serial_tx_data
  import serial_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [CHAR_W-1:0] wrData,
  input  logic              fifoMode,
  input  logic [1:0]        wordLen,
  input  logic              parityOdd,
  output logic              bufEmpty,
  output logic              bufRoom,
  output logic              shiftLsb,
  output logic              parityBit
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [CHAR_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;
  logic [CNT_W-1:0]  capacity;
  logic [CHAR_W-1:0] charMask;
  logic [CHAR_W-1:0] headMasked;
  logic [CHAR_W-1:0] shiftReg;
  logic              parityReg;

  assign capacity = fifoMode ? CNT_W'(DEPTH) : CNT_W'(1);
  assign bufEmpty = (fill == '0);
  assign bufRoom  = (fill < capacity);

  // Bits beyond the selected word length are forced to zero.
  always_comb begin
    for (int i = 0; i < CHAR_W; i++) begin
      charMask[i] = (4'(i) < ({2'b00, wordLen} + 4'(MIN_CHAR)));
    end
  end

  assign headMasked = store[rdPtr] & charMask;

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      store[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (strobe.push) begin
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      end
      if (strobe.load) begin
        rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      end
      case ({strobe.push, strobe.load})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityReg <= 1'b0;
    end else if (strobe.load) begin
      shiftReg  <= headMasked;
      parityReg <= (^headMasked) ^ parityOdd;
    end else if (strobe.shift) begin
      shiftReg  <= {1'b0, shiftReg[CHAR_W-1:1]};
    end
  end

  assign shiftLsb  = shiftReg[0];
  assign parityBit = parityReg;

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       wrValid,
  input  logic       bufEmpty,
  input  logic       bufRoom,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic       irqEnable,
  input  logic       irqAck,
  input  logic       shiftLsb,
  input  logic       parityBit,
  output txStrobe_t  strobe,
  output logic       txd,
  output logic       busy,
  output logic       txIrq
);

  localparam int unsigned TICK_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(OVERSAMPLE - 1);

  txState_t          state, stateNext;
  logic [TICK_W-1:0] tickCnt;
  logic [2:0]        bitIdx;
  logic [2:0]        lastIdx;
  logic              bitEnd;
  logic              frameEnd;
  logic              loadNow;
  logic              holdEmptyQ;
  logic              emptyRise;
  logic              irqPend;

  assign lastIdx  = 3'({1'b0, wordLen} + 3'(MIN_CHAR - 1));
  assign bitEnd   = tick16 && (tickCnt == LAST_TICK);
  assign frameEnd = (state == TX_STOP) && bitEnd;
  assign loadNow  = !bufEmpty && ((state == TX_IDLE) || frameEnd);

  always_comb begin
    strobe.load  = loadNow;
    strobe.push  = wrValid && (bufRoom || loadNow);
    strobe.shift = (state == TX_DATA) && bitEnd;
  end

  always_comb begin
    stateNext = state;
    case (state)
      TX_IDLE:   if (loadNow) stateNext = TX_START;
      TX_START:  if (bitEnd) stateNext = TX_DATA;
      TX_DATA:   if (bitEnd && (bitIdx == lastIdx))
                   stateNext = parityEn ? TX_PARITY : TX_STOP;
      TX_PARITY: if (bitEnd) stateNext = TX_STOP;
      TX_STOP:   if (bitEnd) stateNext = loadNow ? TX_START : TX_IDLE;
      default:   stateNext = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= TX_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state <= stateNext;
      if (loadNow || state == TX_IDLE) begin
        tickCnt <= '0;
      end else if (tick16) begin
        tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
      end
      if (state != TX_DATA) begin
        bitIdx <= '0;
      end else if (bitEnd) begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      TX_START:  txd = 1'b0;
      TX_DATA:   txd = shiftLsb;
      TX_PARITY: txd = parityBit;
      default:   txd = 1'b1;
    endcase
  end

  assign busy = (state != TX_IDLE);

  // Interrupt latches on the holding stage turning empty.
  assign emptyRise = bufEmpty && !holdEmptyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdEmptyQ <= 1'b1;
      irqPend    <= 1'b0;
    end else begin
      holdEmptyQ <= bufEmpty;
      if (wrValid) begin
        irqPend <= 1'b0;
      end else if (emptyRise) begin
        irqPend <= 1'b1;
      end else if (irqAck) begin
        irqPend <= 1'b0;
      end
    end
  end

  assign txIrq = irqPend && irqEnable;

endmodule

// File: rtl/serial_tx_path.sv
module serial_tx_path
  import serial_tx_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       fifoMode,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       irqEnable,
  input  logic       irqAck,
  output logic       txd,
  output logic       holdEmpty,
  output logic       txEmpty,
  output logic       txIrq
);

  txStrobe_t strobe;
  logic      bufEmpty;
  logic      bufRoom;
  logic      shiftLsb;
  logic      parityBit;
  logic      shiftBusy;

  serial_tx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick16    (tick16),
    .wrValid   (wrValid),
    .bufEmpty  (bufEmpty),
    .bufRoom   (bufRoom),
    .wordLen   (wordLen),
    .parityEn  (parityEn),
    .irqEnable (irqEnable),
    .irqAck    (irqAck),
    .shiftLsb  (shiftLsb),
    .parityBit (parityBit),
    .strobe    (strobe),
    .txd       (txd),
    .busy      (shiftBusy),
    .txIrq     (txIrq)
  );

  serial_tx_data #(.DEPTH(DEPTH)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .fifoMode  (fifoMode),
    .wordLen   (wordLen),
    .parityOdd (parityOdd),
    .bufEmpty  (bufEmpty),
    .bufRoom   (bufRoom),
    .shiftLsb  (shiftLsb),
    .parityBit (parityBit)
  );

  assign holdEmpty = bufEmpty;
  assign txEmpty   = bufEmpty && !shiftBusy;

endmodule

// File: rtl/serial_tx_path_chk.sv
module serial_tx_path_chk (
  input logic clk,
  input logic rstN,
  input logic tick16,
  input logic wrValid,
  input logic irqEnable,
  input logic txd,
  input logic holdEmpty,
  input logic txEmpty,
  input logic txIrq,
  input logic shiftBusy
);

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txd);

  assert_line_frozen_without_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (shiftBusy && !tick16) |=> $stable(txd));

  assert_empty_needs_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (holdEmpty && !wrValid) |=> holdEmpty);

  assert_all_empty_implies_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);

  assert_irq_only_when_drained_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txIrq) && irqEnable && $past(irqEnable)) |-> holdEmpty);

  assert_write_clears_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !txIrq);

endmodule

bind serial_tx_path serial_tx_path_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick16    (tick16),
  .wrValid   (wrValid),
  .irqEnable (irqEnable),
  .txd       (txd),
  .holdEmpty (holdEmpty),
  .txEmpty   (txEmpty),
  .txIrq     (txIrq),
  .shiftBusy (shiftBusy)
);

// File: tb/serial_tx_path_tb.sv
`timescale 1ns/1ps
module serial_tx_path_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick16;
  logic       fifoMode;
  logic [1:0] wordLen;
  logic       parityEn;
  logic       parityOdd;
  logic       wrValid;
  logic [7:0] wrData;
  logic       irqEnable;
  logic       irqAck;
  logic       txd, holdEmpty, txEmpty, txIrq;

  logic       tickRun;
  logic       tickPh;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] rxData [0:255];
  logic       rxPar  [0:255];
  logic       rxFrameOk [0:255];
  int         rxCount = 0;
  int         b2bCount = 0;

  always #5 clk = ~clk;

  serial_tx_path u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .fifoMode(fifoMode),
    .wordLen(wordLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .wrValid(wrValid), .wrData(wrData), .irqEnable(irqEnable), .irqAck(irqAck),
    .txd(txd), .holdEmpty(holdEmpty), .txEmpty(txEmpty), .txIrq(txIrq)
  );

  // Enable pulse every second cycle while tickRun is set.
  always @(posedge clk) begin
    if (!rstN) begin
      tickPh <= 1'b0;
      tick16 <= 1'b0;
    end else begin
      tickPh <= ~tickPh;
      tick16 <= tickRun & tickPh;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Line decoder: samples each bit at its middle by counting ticks.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txd == 1'b0) begin
        bit more;
        more = 1'b1;
        while (more) begin
          automatic int nd = int'(wordLen) + 5;
          automatic int np = parityEn ? 1 : 0;
          automatic int nb = 1 + nd + np;
          automatic int c = 0;
          automatic logic [15:0] bits = '0;
          automatic logic [7:0] d = '0;
          for (int b = 0; b <= nb; b++) begin
            while (c != 16 * b + 8) begin
              if (tick16) c++;
              @(negedge clk);
            end
            bits[b] = txd;
          end
          while (c != 16 * (nb + 1)) begin
            if (tick16) c++;
            @(negedge clk);
          end
          for (int i = 0; i < nd; i++) d[i] = bits[1 + i];
          rxData[rxCount & 255]    = d;
          rxPar[rxCount & 255]     = np ? bits[1 + nd] : 1'b0;
          rxFrameOk[rxCount & 255] = (bits[0] == 1'b0) && (bits[nb] == 1'b1);
          rxCount++;
          more = (txd == 1'b0);
          if (more) b2bCount++;
        end
      end
    end
  end

  task automatic waitIdle();
    while (!txEmpty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] maskOf(input logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  task automatic checkFrame(input int idx, input logic [7:0] sent, input string tag);
    automatic logic [7:0] exp = sent & maskOf(wordLen);
    chk({tag, " R1 framing"}, int'(rxFrameOk[idx & 255]), 1);
    chk({tag, " R1 data"}, int'(rxData[idx & 255]), int'(exp));
    if (parityEn) begin
      chk({tag, " R3 parity"}, int'(rxPar[idx & 255]), int'((^exp) ^ parityOdd));
    end
  endtask

  initial begin
    automatic int base;
    rstN = 1'b0; fifoMode = 1'b0; wordLen = 2'd3; parityEn = 1'b0; parityOdd = 1'b0;
    wrValid = 1'b0; wrData = '0; irqEnable = 1'b0; irqAck = 1'b0; tickRun = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 txd", int'(txd), 1);
    chk("R11 holdEmpty", int'(holdEmpty), 1);
    chk("R11 txEmpty", int'(txEmpty), 1);
    chk("R11 txIrq", int'(txIrq), 0);
    irqEnable = 1'b1;
    repeat (40) @(negedge clk);
    chk("R9 no irq from reset emptiness", int'(txIrq), 0);

    // Sweep every word length and parity setting, single-register mode.
    for (int cfg = 0; cfg < 16; cfg++) begin
      wordLen = cfg[1:0]; parityEn = cfg[2]; parityOdd = cfg[3];
      for (int k = 0; k < 2; k++) begin
        automatic logic [7:0] sent = 8'h5A ^ 8'(cfg * 29) ^ (k[0] ? 8'hC3 : 8'h00);
        base = rxCount;
        @(negedge clk); wrValid = 1'b1; wrData = sent;
        @(negedge clk); wrValid = 1'b0;
        chk("R6 holdEmpty after write", int'(holdEmpty), 0);
        chk("R7 txEmpty after write", int'(txEmpty), 0);
        @(negedge clk);
        chk("R6 holdEmpty after transfer", int'(holdEmpty), 1);
        chk("R7 txEmpty while shifting", int'(txEmpty), 0);
        @(negedge clk);
        chk("R9 irq on drain", int'(txIrq), 1);
        irqAck = 1'b1;
        @(negedge clk); irqAck = 1'b0;
        chk("R10 ack clears irq", int'(txIrq), 0);
        waitIdle();
        chk("R1 one frame", rxCount - base, 1);
        checkFrame(base, sent, "sweep");
      end
    end

    // R2: pausing the enable freezes the line mid-frame.
    wordLen = 2'd3; parityEn = 1'b1; parityOdd = 1'b0;
    base = rxCount;
    @(negedge clk); wrValid = 1'b1; wrData = 8'h96;
    @(negedge clk); wrValid = 1'b0;
    repeat (100) @(negedge clk);
    tickRun = 1'b0;
    repeat (2) @(negedge clk);
    begin
      automatic logic held = txd;
      automatic int moved = 0;
      repeat (60) begin
        @(negedge clk);
        if (txd != held) moved++;
      end
      chk("R2 line frozen without tick", moved, 0);
    end
    tickRun = 1'b1;
    waitIdle();
    chk("R2 frame after pause count", rxCount - base, 1);
    checkFrame(base, 8'h96, "R2 pause");
    irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;

    // R4: single register, three writes in consecutive cycles.
    parityEn = 1'b0;
    base = rxCount;
    @(negedge clk); wrValid = 1'b1; wrData = 8'h11;
    @(negedge clk); wrData = 8'h22;
    @(negedge clk); wrData = 8'h33;
    @(negedge clk); wrValid = 1'b0;
    waitIdle();
    chk("R4 single mode frames", rxCount - base, 2);
    chk("R4 first byte", int'(rxData[base & 255]), 32'h11);
    chk("R4 byte taken during transfer", int'(rxData[(base + 1) & 255]), 32'h22);
    irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;

    // R5 and R8: buffered mode, 18 writes back to back.
    fifoMode = 1'b1;
    base = rxCount;
    begin
      automatic int b2bBase = b2bCount;
      for (int i = 0; i < 18; i++) begin
        @(negedge clk); wrValid = 1'b1; wrData = 8'(i * 17 + 3);
      end
      @(negedge clk); wrValid = 1'b0;
      chk("R6 holdEmpty with buffered data", int'(holdEmpty), 0);
      waitIdle();
      chk("R5 frames sent, overflow dropped", rxCount - base, 17);
      for (int i = 0; i < 17; i++) begin
        chk("R5 buffer order", int'(rxData[(base + i) & 255]), (i * 17 + 3) & 255);
      end
      chk("R8 back-to-back frames", b2bCount - b2bBase, 16);
    end
    chk("R9 irq after buffer drains", int'(txIrq), 1);

    // R9 masking and R10 write clearing.
    irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;
    irqEnable = 1'b0;
    @(negedge clk); wrValid = 1'b1; wrData = 8'h5C;
    @(negedge clk); wrValid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 masked irq hidden", int'(txIrq), 0);
    irqEnable = 1'b1;
    #1;
    chk("R9 pending survives mask", int'(txIrq), 1);
    @(negedge clk); wrValid = 1'b1; wrData = 8'hA3;
    @(negedge clk); wrValid = 1'b0;
    chk("R10 write clears irq", int'(txIrq), 0);
    waitIdle();
    chk("R1 last bytes", int'(rxData[(rxCount - 1) & 255]), 32'hA3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule